// File: doc/BRIEF.md
# Memory Control Register Bank with Per-Memory Write Locks

This block is a 32-bit register bank that controls a set of on-chip RAM instances. The instances are arranged in groups of equal size. Each group owns four register words: a lock word, a test-mode word, an initialization-start word and an initialization-done word. Every memory in a group has one lock bit, one 2-bit test-mode field, one start bit and one done bit in those words.

Software reaches the bank over a simple register bus. The bus carries an address, a write enable and write data, and read data comes back combinationally. The bank drives the test-mode field of each memory and a one-cycle start pulse to that memory's initialization engine. It takes a done input back from each engine.

A lock bit that is set freezes the test-mode field and the start bit of its own memory. The lock word itself stays writable, so a lock can be cleared again.

Top module: `memctl_regbank`

## Requirements
- R1: After reset every mapped word reads 0, `mem_mode` is all zero and `init_start` is all zero.
- R2: The lock word of a group (group offset 0h) stores bit m as the lock of memory m of that group. Bits at and above the group's memory count read 0 whatever was written to them.
- R3: The test word (group offset 4h) holds the 2-bit mode of memory m in bits 2m+1:2m. Bits at and above twice the memory count read 0.
- R4: While memory m's lock bit is 1, a write to the test word leaves that memory's mode unchanged, and the modes of unlocked memories in the same word still update.
- R5: Writing 1 to bit m of the start word (group offset 8h) of an unlocked memory raises that memory's `init_start` bit for exactly the one cycle after the write edge. Writing 0 raises no pulse.
- R6: The start word always reads 0.
- R7: For a locked memory, a 1 written to its start bit raises no pulse and leaves its done bit unchanged.
- R8: The done word (group offset Ch) bit m goes to 1 one edge after `init_done_in` for that memory is seen high, and clears when a new start is accepted for that memory. Writes to the done word have no effect.
- R9: The lock word remains writable while lock bits are set, so writing 0 clears the locks and makes the test and start fields writable again.
- R10: The group base is the group index times 20h. Offsets 10h to 1Ch inside a group, addresses that are not word aligned, and groups at or beyond the group count read 0, and writes to them change no register.
- R11: `mem_mode` carries the test field of global memory index g*MEMS_PER_GRP+m in bits 2i+1:2i, where i is that index, and it follows the stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| init_done_in | input | NUM_GRP*MEMS_PER_GRP | Completion from each memory's initialization engine |
| init_start | output | NUM_GRP*MEMS_PER_GRP | One-cycle start pulse to each initialization engine |
| mem_mode | output | 2*NUM_GRP*MEMS_PER_GRP | Test-mode field of each memory, 2 bits per memory |

## Verification
The bench builds the bank with three groups of five memories and an 8-bit address. Five memories leave a 10-bit test field, so write data with every bit set shows that the reserved upper bits and the unused lock and done bits read 0. Three groups leave a fourth group slot at 60h that falls inside the address range but maps to nothing, and that slot is the out-of-range case for R10. Locking two of the five memories in one group lets single writes show locked and unlocked fields side by side.

// File: rtl/memctl_pkg.sv
package memctl_pkg;
  // byte span of one register group is 2**GRP_SPAN_LG2
  localparam int unsigned GRP_SPAN_LG2 = 5;
  localparam int unsigned MODE_W       = 2;

  // word inside a group, decoded from address bits 3:2
  typedef enum logic [1:0] {
    SEL_LOCK = 2'd0,
    SEL_TEST = 2'd1,
    SEL_INIT = 2'd2,
    SEL_DONE = 2'd3
  } word_sel_e;
endpackage

// File: rtl/memctl_decode.sv
module memctl_decode
  import memctl_pkg::*;
#(
  parameter int unsigned NUM_GRP = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_GRP-1:0] grp_hit,
  output word_sel_e          sel
);
  localparam int unsigned GF_W = ADDR_W - GRP_SPAN_LG2;

  logic [GF_W-1:0] grp_field;
  logic            in_window;

  assign grp_field = addr[ADDR_W-1:GRP_SPAN_LG2];
  // upper half of each group span and unaligned addresses map to nothing
  assign in_window = (addr[GRP_SPAN_LG2-1] == 1'b0) && (addr[1:0] == 2'b00);
  assign sel       = word_sel_e'(addr[3:2]);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_hit
    assign grp_hit[g] = in_window && (grp_field == GF_W'(g));
  end
endmodule

// File: rtl/memctl_group.sv
module memctl_group
  import memctl_pkg::*;
#(
  parameter int unsigned MEMS   = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  word_sel_e              sel,
  input  logic [MODE_W*MEMS-1:0] wdata,
  input  logic [MEMS-1:0]        done_in,
  output logic [MEMS-1:0]        lock_o,
  output logic [MODE_W*MEMS-1:0] mode_o,
  output logic [MEMS-1:0]        start_o,
  output logic [MEMS-1:0]        done_o,
  output logic [DATA_W-1:0]      rdata_o
);
  localparam int unsigned FLD_W = MODE_W * MEMS;

  logic [MEMS-1:0]  lock_q,  lock_d;
  logic [FLD_W-1:0] mode_q,  mode_d;
  logic [MEMS-1:0]  start_q, start_d;
  logic [MEMS-1:0]  done_q,  done_d;
  logic             lock_en, mode_en, init_wr;

  assign lock_en = wr_en && (sel == SEL_LOCK);
  assign mode_en = wr_en && (sel == SEL_TEST);
  assign init_wr = wr_en && (sel == SEL_INIT);

  // next state
  always_comb begin
    lock_d  = wdata[MEMS-1:0];
    mode_d  = mode_q;
    start_d = '0;
    done_d  = done_q | done_in;
    for (int m = 0; m < MEMS; m++) begin
      if (!lock_q[m]) begin
        mode_d[MODE_W*m +: MODE_W] = wdata[MODE_W*m +: MODE_W];
      end
      if (init_wr && wdata[m] && !lock_q[m]) begin
        start_d[m] = 1'b1;
        done_d[m]  = 1'b0;   // a fresh start wins over a completion
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= '0;
      mode_q  <= '0;
      start_q <= '0;
      done_q  <= '0;
    end else begin
      if (lock_en) lock_q <= lock_d;
      if (mode_en) mode_q <= mode_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  // read view of the selected word
  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_LOCK: rdata_o[MEMS-1:0]  = lock_q;
      SEL_TEST: rdata_o[FLD_W-1:0] = mode_q;
      SEL_DONE: rdata_o[MEMS-1:0]  = done_q;
      default:  rdata_o            = '0;   // start word reads as zero
    endcase
  end

  assign lock_o  = lock_q;
  assign mode_o  = mode_q;
  assign start_o = start_q;
  assign done_o  = done_q;
endmodule

// File: rtl/memctl_rdmux.sv
module memctl_rdmux #(
  parameter int unsigned NUM_GRP = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic [NUM_GRP-1:0]        grp_hit,
  input  logic [NUM_GRP*DATA_W-1:0] grp_rdata,
  output logic [DATA_W-1:0]         rdata
);
  // AND-OR select; at most one group hit, none gives zero
  always_comb begin
    rdata = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      rdata = rdata | (grp_rdata[g*DATA_W +: DATA_W] & {DATA_W{grp_hit[g]}});
    end
  end
endmodule

// File: rtl/memctl_regbank.sv
module memctl_regbank
  import memctl_pkg::*;
#(
  parameter int unsigned NUM_GRP      = 4,
  parameter int unsigned MEMS_PER_GRP = 4,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DATA_W       = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  reg_we,
  input  logic [ADDR_W-1:0]                     reg_addr,
  input  logic [DATA_W-1:0]                     reg_wdata,
  output logic [DATA_W-1:0]                     reg_rdata,
  input  logic [NUM_GRP*MEMS_PER_GRP-1:0]       init_done_in,
  output logic [NUM_GRP*MEMS_PER_GRP-1:0]       init_start,
  output logic [MODE_W*NUM_GRP*MEMS_PER_GRP-1:0] mem_mode
);
  localparam int unsigned NUM_MEM = NUM_GRP * MEMS_PER_GRP;
  localparam int unsigned FLD_W   = MODE_W * MEMS_PER_GRP;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_GRP-1:0]        grp_hit;
  word_sel_e                 sel;
  logic [NUM_GRP*DATA_W-1:0] grp_rdata;
  logic [NUM_MEM-1:0]        lock_vec;
  logic [NUM_MEM-1:0]        done_vec;

  memctl_decode #(
    .NUM_GRP (NUM_GRP),
    .ADDR_W  (ADDR_W)
  ) u_decode (
    .addr    (reg_addr),
    .grp_hit (grp_hit),
    .sel     (sel)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    memctl_group #(
      .MEMS   (MEMS_PER_GRP),
      .DATA_W (DATA_W)
    ) u_group (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_en   (reg_we && grp_hit[g]),
      .sel     (sel),
      .wdata   (reg_wdata[FLD_W-1:0]),
      .done_in (init_done_in[g*MEMS_PER_GRP +: MEMS_PER_GRP]),
      .lock_o  (lock_vec[g*MEMS_PER_GRP +: MEMS_PER_GRP]),
      .mode_o  (mem_mode[g*FLD_W +: FLD_W]),
      .start_o (init_start[g*MEMS_PER_GRP +: MEMS_PER_GRP]),
      .done_o  (done_vec[g*MEMS_PER_GRP +: MEMS_PER_GRP]),
      .rdata_o (grp_rdata[g*DATA_W +: DATA_W])
    );
  end

  memctl_rdmux #(
    .NUM_GRP (NUM_GRP),
    .DATA_W  (DATA_W)
  ) u_rdmux (
    .grp_hit   (grp_hit),
    .grp_rdata (grp_rdata),
    .rdata     (reg_rdata)
  );

  // write data above the widest field is reserved
  if (FLD_W < DATA_W) begin : g_wdata_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:FLD_W];
  end
endmodule

// File: rtl/memctl_regbank_chk.sv
module memctl_regbank_chk #(
  parameter int unsigned NUM_GRP      = 4,
  parameter int unsigned MEMS_PER_GRP = 4,
  parameter int unsigned DATA_W       = 32
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                reg_we,
  input logic [DATA_W-1:0]                   reg_rdata,
  input logic [NUM_GRP*MEMS_PER_GRP-1:0]     init_start,
  input logic [2*NUM_GRP*MEMS_PER_GRP-1:0]   mem_mode,
  input logic [NUM_GRP*MEMS_PER_GRP-1:0]     lock_vec,
  input logic [NUM_GRP*MEMS_PER_GRP-1:0]     done_vec
);
  localparam int unsigned NUM_MEM = NUM_GRP * MEMS_PER_GRP;
  localparam int unsigned FLD_W   = 2 * MEMS_PER_GRP;

  AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|init_start) |-> $past(reg_we)); // R5

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_mem
    AST_MODE_FROZEN_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_vec[i]) |-> $stable(mem_mode[2*i +: 2])); // R4
    AST_NO_START_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      init_start[i] |-> !$past(lock_vec[i])); // R7
    AST_DONE_LOW_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      init_start[i] |-> !done_vec[i]); // R8
  end

  if (FLD_W < DATA_W) begin : g_rsv
    AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:FLD_W] == '0); // R3
  end
endmodule

bind memctl_regbank memctl_regbank_chk #(
  .NUM_GRP      (NUM_GRP),
  .MEMS_PER_GRP (MEMS_PER_GRP),
  .DATA_W       (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_rdata  (reg_rdata),
  .init_start (init_start),
  .mem_mode   (mem_mode),
  .lock_vec   (lock_vec),
  .done_vec   (done_vec)
);

// File: tb/memctl_regbank_bench.sv
module memctl_regbank_bench;
  localparam int unsigned NG   = 3;
  localparam int unsigned NM   = 5;
  localparam int unsigned AW   = 8;
  localparam int unsigned DW   = 32;
  localparam int unsigned NMEM = NG * NM;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            reg_we;
  logic [AW-1:0]   reg_addr;
  logic [DW-1:0]   reg_wdata;
  logic [DW-1:0]   reg_rdata;
  logic [NMEM-1:0] init_done_in;
  logic [NMEM-1:0] init_start;
  logic [2*NMEM-1:0] mem_mode;

  int n_cmp  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  bit            rd_pend = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  memctl_regbank #(
    .NUM_GRP(NG), .MEMS_PER_GRP(NM), .ADDR_W(AW), .DATA_W(DW)
  ) u_memctl_regbank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .init_done_in(init_done_in),
    .init_start(init_start), .mem_mode(mem_mode)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops one expected read per pending read
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, reg_rdata, e);
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    rd_pend = 1'b1;
    @(negedge clk); #1;
    rd_pend = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  // start write followed by the pulse window: pulse cycle, then the next
  task automatic wr_start(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [NMEM-1:0] exp_pulse, input string t);
    wr(a, d);
    @(negedge clk);
    chk(t, DW'(init_start), DW'(exp_pulse));
    @(negedge clk);
    chk(t, DW'(init_start), '0);
  endtask

  task automatic pulse_done(input int idx);
    @(posedge clk); #1;
    init_done_in[idx] = 1'b1;
    @(posedge clk); #1;
    init_done_in = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; init_done_in = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    for (int g = 0; g < NG; g++) begin
      for (int w = 0; w < 4; w++) rd(AW'(g*32 + w*4), '0, "R1 word after reset");
    end
    @(negedge clk);
    chk("R1 mem_mode after reset", DW'(mem_mode), '0);
    chk("R1 init_start after reset", DW'(init_start), '0);

    // R2: lock word width and reserved bits
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_001F, "R2 lock word masked to 5 bits");
    // R9: lock word writable while locked, unlock reopens test field
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R9 lock cleared while locked");
    wr(8'h04, 32'h0000_0155);
    rd(8'h04, 32'h0000_0155, "R9 test write after unlock");

    // R3 / R11: packed test field
    wr(8'h24, 32'hFFFF_FFE4);
    rd(8'h24, 32'h0000_03E4, "R3 test field packing and reserved bits");
    @(negedge clk);
    chk("R11 mem_mode group1", DW'(mem_mode[19:10]), 32'h3E4);

    // R4: memories 0 and 2 of group1 locked
    wr(8'h20, 32'h0000_0005);
    wr(8'h24, 32'h0);
    rd(8'h24, 32'h0000_0020, "R4 locked modes kept, others cleared");
    wr(8'h24, 32'h0000_03FF);
    rd(8'h24, 32'h0000_03EC, "R4 locked modes kept, others set");
    @(negedge clk);
    chk("R11 mem_mode group1 after lock", DW'(mem_mode[19:10]), 32'h3EC);

    // R5 / R6: start pulse on group2 memory1 (global 11)
    wr_start(8'h48, 32'h0000_0002, NMEM'(1) << 11, "R5 start pulse single cycle");
    wr_start(8'h48, 32'h0, '0, "R5 zero write gives no pulse");
    rd(8'h48, 32'h0, "R6 start word reads zero");

    // R8: done set, done word read-only, cleared by new start
    pulse_done(11);
    rd(8'h4C, 32'h0000_0002, "R8 done set by engine");
    wr(8'h4C, 32'h0000_001F);
    rd(8'h4C, 32'h0000_0002, "R8 done word ignores writes");
    wr_start(8'h48, 32'h0000_0002, NMEM'(1) << 11, "R5 restart pulse");
    rd(8'h4C, 32'h0, "R8 done cleared by new start");

    // R7: group1 memory0 locked, memory1 unlocked
    pulse_done(5);
    rd(8'h2C, 32'h0000_0001, "R8 done group1 memory0");
    wr_start(8'h28, 32'h0000_0003, NMEM'(1) << 6, "R7 locked start suppressed");
    rd(8'h2C, 32'h0000_0001, "R7 locked done kept");

    // R10: unmapped and misaligned addresses
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h64, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h26, 32'h0);
    rd(8'h10, 32'h0, "R10 read offset 10h");
    rd(8'h60, 32'h0, "R10 read group beyond count");
    rd(8'h06, 32'h0, "R10 read misaligned");
    rd(8'h00, 32'h0, "R10 lock group0 unchanged");
    rd(8'h04, 32'h0000_0155, "R10 test group0 unchanged");
    rd(8'h20, 32'h0000_0005, "R10 lock group1 unchanged");
    rd(8'h24, 32'h0000_03EC, "R10 test group1 unchanged");
    rd(8'h44, 32'h0, "R10 test group2 unchanged");
    @(negedge clk);
    chk("R10 no start pulse from unmapped writes", DW'(init_start), '0);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule